// File: doc/BRIEF.md
# Single-Level Page Table Walker

The walker turns a virtual page number into a physical page number when a translation request misses in the lookaside buffer. It takes a 32-bit virtual address and splits it into a 20-bit page number and a 12-bit offset, so pages are 4 KB. It adds four times the page number to the table base pointer of the running process to get the address of the table entry. It reads that one 32-bit word through a simple request/response memory port and decodes it. A resident entry gives an 18-bit physical page number, which is joined with the unchanged offset to form a 30-bit physical address. The other attribute bits of the entry are passed on for the buffer refill. An entry whose valid bit is clear raises a page fault instead, and the fault reports the full faulting virtual address so that execution can restart at that access.

The walker keeps one base register, which is reloaded on each context switch. It serves one walk at a time and moves through three states: idle, reading, and responding. A result stays on the outputs until the requester acknowledges it.

Top module: `pgw_walker`

## Requirements
- R1: After reset, `req_ready` is 1 and `mem_req_valid` and `rsp_valid` are 0. The base register resets to the `RESET_BASE` parameter, which is 0 by default.
- R2: For each accepted request, the walker issues exactly one memory read. Its address is `base + (req_vaddr[31:12] << 2)`, taken modulo 2^32.
- R3: A cycle with `ctx_load` high loads `ctx_base` into the base register. A walk uses the base that was held in the cycle its request was accepted. A load during the walk, or in the same cycle as the acceptance, applies only to later requests.
- R4: If entry bit 31 is 1, the response has `rsp_fault`=0. `rsp_paddr` is `{entry[17:0], vaddr[11:0]}` and `rsp_attr` is `entry[30:18]`, where bit 30 of the entry is the dirty flag.
- R5: If entry bit 31 is 0, the response has `rsp_fault`=1, with `rsp_paddr` and `rsp_attr` both 0. On every response, `rsp_vaddr` equals the full 32-bit virtual address of the request.
- R6: `req_ready` is 1 only while the walker is idle. A `req_valid` raised while a walk is in progress starts no read and does not change the result of that walk.
- R7: `mem_req_valid` stays high with a stable `mem_req_addr` until `mem_req_ready` accepts it. It falls in the cycle after the handshake, and the response may arrive any number of cycles later.
- R8: While `rsp_valid` is high and `rsp_ready` is low, all response outputs hold their values. In the cycle after the handshake the walker is idle again.
- R9: A `mem_rsp_valid` that arrives while no read is outstanding is ignored and produces no response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctx_load | input | 1 | Load a new table base (context switch) |
| ctx_base | input | 32 | Table base pointer of the incoming process |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Walker idle and accepting |
| req_vaddr | input | 32 | Virtual address to translate |
| mem_req_valid | output | 1 | Entry read request |
| mem_req_ready | input | 1 | Memory accepts the read |
| mem_req_addr | output | 32 | Byte address of the table entry |
| mem_rsp_valid | input | 1 | Read data present |
| mem_rsp_data | input | 32 | Table entry word |
| rsp_valid | output | 1 | Translation result present |
| rsp_ready | input | 1 | Requester takes the result |
| rsp_fault | output | 1 | Entry not resident (page fault) |
| rsp_paddr | output | 30 | Physical address, 0 on fault |
| rsp_attr | output | 13 | Entry bits 30:18, 0 on fault |
| rsp_vaddr | output | 32 | Virtual address of this walk |

## Verification
The cases that are hardest to reach from the ports are those where something arrives while a walk is in flight: a context switch that reloads the base, or a second request that must not start a read. The stimulus places both in the cycle right after a request is accepted, while the memory model stretches the walk with a stalled request handshake and a response latency of zero to three cycles. A sweep over three base pointers, one of which wraps past 2^32, and forty page numbers each mixes these cases with held responses. Expected entry addresses and contents are computed arithmetically from the base and the page number.

// File: rtl/pgw_pkg.sv
package pgw_pkg;
    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_READ    = 2'd1,
        ST_RESPOND = 2'd2
    } walk_st_e;
endpackage

// File: rtl/pgw_entry_addr.sv
// Byte address of the table entry for a virtual page number.
module pgw_entry_addr #(
    parameter int VA_W        = 32,
    parameter int VPN_W       = 20,
    parameter int ENTRY_SHIFT = 2
) (
    input  logic [VA_W-1:0]  base,
    input  logic [VPN_W-1:0] vpn,
    output logic [VA_W-1:0]  addr
);
    localparam int PAD_W = VA_W - VPN_W;

    logic [VA_W-1:0] vpn_ext;

    always_comb begin
        vpn_ext = {{PAD_W{1'b0}}, vpn};
        addr    = base + (vpn_ext << ENTRY_SHIFT);
    end
endmodule

// File: rtl/pgw_pte_decode.sv
// Splits a table entry into the resident flag, frame number and attributes.
module pgw_pte_decode #(
    parameter int PTE_W = 32,
    parameter int PPN_W = 18
) (
    input  logic [PTE_W-1:0]         pte,
    output logic                     resident,
    output logic [PPN_W-1:0]         ppn,
    output logic [PTE_W-PPN_W-2:0]   attr
);
    localparam int VALID_BIT = PTE_W - 1;

    always_comb begin
        resident = pte[VALID_BIT];
        ppn      = pte[PPN_W-1:0];
        attr     = pte[VALID_BIT-1:PPN_W];
    end
endmodule

// File: rtl/pgw_walker.sv
module pgw_walker #(
    parameter int          VA_W       = 32,
    parameter int          OFF_W      = 12,
    parameter int          PA_W       = 30,
    parameter int          PTE_W      = 32,
    parameter logic [31:0] RESET_BASE = 32'h0
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          ctx_load,
    input  logic [VA_W-1:0]               ctx_base,
    input  logic                          req_valid,
    output logic                          req_ready,
    input  logic [VA_W-1:0]               req_vaddr,
    output logic                          mem_req_valid,
    input  logic                          mem_req_ready,
    output logic [VA_W-1:0]               mem_req_addr,
    input  logic                          mem_rsp_valid,
    input  logic [PTE_W-1:0]              mem_rsp_data,
    output logic                          rsp_valid,
    input  logic                          rsp_ready,
    output logic                          rsp_fault,
    output logic [PA_W-1:0]               rsp_paddr,
    output logic [PTE_W-(PA_W-OFF_W)-2:0] rsp_attr,
    output logic [VA_W-1:0]               rsp_vaddr
);
    import pgw_pkg::*;

    localparam int VPN_W       = VA_W - OFF_W;
    localparam int PPN_W       = PA_W - OFF_W;
    localparam int ATTR_W      = PTE_W - PPN_W - 1;
    localparam int ENTRY_SHIFT = $clog2(PTE_W / 8);

    typedef struct packed {
        walk_st_e          st;
        logic              issued;
        logic              fault;
        logic [VA_W-1:0]   base;
        logic [VA_W-1:0]   vaddr;
        logic [VA_W-1:0]   ent;
        logic [PA_W-1:0]   paddr;
        logic [ATTR_W-1:0] attr;
    } walk_regs_t;

    walk_regs_t r_d, r_q;

    logic [VA_W-1:0]   ent_calc;
    logic              pte_resident;
    logic [PPN_W-1:0]  pte_ppn;
    logic [ATTR_W-1:0] pte_attr;

    pgw_entry_addr #(
        .VA_W(VA_W), .VPN_W(VPN_W), .ENTRY_SHIFT(ENTRY_SHIFT)
    ) u_eaddr (
        .base (r_q.base),
        .vpn  (req_vaddr[VA_W-1:OFF_W]),
        .addr (ent_calc)
    );

    pgw_pte_decode #(
        .PTE_W(PTE_W), .PPN_W(PPN_W)
    ) u_dec (
        .pte      (mem_rsp_data),
        .resident (pte_resident),
        .ppn      (pte_ppn),
        .attr     (pte_attr)
    );

    always_comb begin
        r_d = r_q;
        if (ctx_load) begin
            r_d.base = ctx_base;
        end
        case (r_q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    r_d.vaddr  = req_vaddr;
                    r_d.ent    = ent_calc;
                    r_d.issued = 1'b0;
                    r_d.st     = ST_READ;
                end
            end
            ST_READ: begin
                if (!r_q.issued && mem_req_ready) begin
                    r_d.issued = 1'b1;
                end
                if (r_q.issued && mem_rsp_valid) begin
                    r_d.fault = !pte_resident;
                    if (pte_resident) begin
                        r_d.paddr = {pte_ppn, r_q.vaddr[OFF_W-1:0]};
                        r_d.attr  = pte_attr;
                    end else begin
                        r_d.paddr = '0;
                        r_d.attr  = '0;
                    end
                    r_d.st = ST_RESPOND;
                end
            end
            ST_RESPOND: begin
                if (rsp_ready) begin
                    r_d.st = ST_IDLE;
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q        <= '0;
            r_q.st     <= ST_IDLE;
            r_q.base   <= RESET_BASE[VA_W-1:0];
        end else begin
            r_q <= r_d;
        end
    end

    assign req_ready     = (r_q.st == ST_IDLE);
    assign mem_req_valid = (r_q.st == ST_READ) && !r_q.issued;
    assign mem_req_addr  = r_q.ent;
    assign rsp_valid     = (r_q.st == ST_RESPOND);
    assign rsp_fault     = r_q.fault;
    assign rsp_paddr     = r_q.paddr;
    assign rsp_attr      = r_q.attr;
    assign rsp_vaddr     = r_q.vaddr;
endmodule

// File: rtl/pgw_walker_chk.sv
module pgw_walker_chk #(
    parameter int VA_W   = 32,
    parameter int OFF_W  = 12,
    parameter int PA_W   = 30,
    parameter int ATTR_W = 13
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic [VA_W-1:0]   req_vaddr,
    input logic              mem_req_valid,
    input logic              mem_req_ready,
    input logic [VA_W-1:0]   mem_req_addr,
    input logic              mem_rsp_valid,
    input logic              rsp_valid,
    input logic              rsp_ready,
    input logic              rsp_fault,
    input logic [PA_W-1:0]   rsp_paddr,
    input logic [ATTR_W-1:0] rsp_attr,
    input logic [VA_W-1:0]   rsp_vaddr
);
    logic [VA_W-1:0] cap_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_q <= '0;
        end else if (req_valid && req_ready) begin
            cap_q <= req_vaddr;
        end
    end

    p_idle_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (!rsp_valid && !mem_req_valid));

    p_req_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

    p_one_read_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && mem_req_ready) |=> !mem_req_valid);

    p_rsp_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_paddr)
                                       && $stable(rsp_fault) && $stable(rsp_attr)));

    p_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_ready) |=> req_ready);

    p_fault_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_fault) |-> (rsp_paddr == '0 && rsp_attr == '0));

    p_vaddr_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (rsp_vaddr == cap_q));

    p_offset_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_fault) |-> (rsp_paddr[OFF_W-1:0] == cap_q[OFF_W-1:0]));

    p_stray_rsp_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (req_ready && !req_valid && mem_rsp_valid) |=> req_ready);
endmodule

bind pgw_walker pgw_walker_chk #(
    .VA_W(VA_W), .OFF_W(OFF_W), .PA_W(PA_W), .ATTR_W(PTE_W - (PA_W - OFF_W) - 1)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_valid     (req_valid),
    .req_ready     (req_ready),
    .req_vaddr     (req_vaddr),
    .mem_req_valid (mem_req_valid),
    .mem_req_ready (mem_req_ready),
    .mem_req_addr  (mem_req_addr),
    .mem_rsp_valid (mem_rsp_valid),
    .rsp_valid     (rsp_valid),
    .rsp_ready     (rsp_ready),
    .rsp_fault     (rsp_fault),
    .rsp_paddr     (rsp_paddr),
    .rsp_attr      (rsp_attr),
    .rsp_vaddr     (rsp_vaddr)
);

// File: tb/sim_pgw_walker.sv
`timescale 1ns/1ps
module sim_pgw_walker;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ctx_load = 1'b0;
    logic [31:0] ctx_base = '0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_vaddr = '0;
    logic        mem_req_valid;
    logic        mem_req_ready = 1'b0;
    logic [31:0] mem_req_addr;
    logic        mem_rsp_valid = 1'b0;
    logic [31:0] mem_rsp_data = '0;
    logic        rsp_valid;
    logic        rsp_ready = 1'b0;
    logic        rsp_fault;
    logic [29:0] rsp_paddr;
    logic [12:0] rsp_attr;
    logic [31:0] rsp_vaddr;

    int checks = 0;
    int failures = 0;
    int mlat = 0;
    bit mstall = 1'b0;
    int seen_cnt = 0;
    logic [31:0] seen_addr = '0;
    logic [31:0] cur_base = '0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    pgw_walker u0 (
        .clk(clk), .rst_n(rst_n), .ctx_load(ctx_load), .ctx_base(ctx_base),
        .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
        .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
        .mem_rsp_data(mem_rsp_data), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
        .rsp_fault(rsp_fault), .rsp_paddr(rsp_paddr), .rsp_attr(rsp_attr),
        .rsp_vaddr(rsp_vaddr)
    );

    // Table contents as a function of the entry address.
    function automatic logic [31:0] pte_of(input logic [31:0] a);
        logic v;
        v = (a[4:2] != 3'b101) && (a[4:2] != 3'b010);
        return {v, a[31:19], a[19:2] ^ 18'h15A3C};
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
        end
    endtask

    // Memory model: optional request stall, variable response latency.
    initial begin
        forever begin
            @(negedge clk);
            if (mem_req_valid) begin
                if (mstall) repeat (2) @(negedge clk);
                mem_req_ready = 1'b1;
                seen_addr = mem_req_addr;
                seen_cnt++;
                @(posedge clk);
                @(negedge clk);
                mem_req_ready = 1'b0;
                repeat (mlat) @(negedge clk);
                mem_rsp_valid = 1'b1;
                mem_rsp_data = pte_of(seen_addr);
                @(negedge clk);
                mem_rsp_valid = 1'b0;
                mem_rsp_data = '0;
            end
        end
    end

    task automatic set_base(input logic [31:0] b);
        @(negedge clk);
        ctx_load = 1'b1;
        ctx_base = b;
        @(negedge clk);
        ctx_load = 1'b0;
        cur_base = b;
    endtask

    task automatic walk(input logic [31:0] va, input int hold, input bit intrude,
                        input bit ctxmid, input logic [31:0] newbase);
        logic [31:0] ea;
        logic [31:0] pte;
        logic [29:0] p0;
        bit f0;
        int start_cnt;
        int guard;
        ea = cur_base + {10'd0, va[31:12], 2'b00};
        pte = pte_of(ea);
        start_cnt = seen_cnt;
        @(negedge clk);
        chk(req_ready == 1'b1, "R6", "ready before request", {31'd0, req_ready}, 32'd1);
        req_valid = 1'b1;
        req_vaddr = va;
        @(negedge clk);
        if (intrude) begin
            req_vaddr = va ^ 32'hFFFFF000;
            chk(req_ready == 1'b0, "R6", "busy ready", {31'd0, req_ready}, 32'd0);
        end else begin
            req_valid = 1'b0;
        end
        if (ctxmid) begin
            ctx_load = 1'b1;
            ctx_base = newbase;
        end
        @(negedge clk);
        req_valid = 1'b0;
        ctx_load = 1'b0;
        guard = 0;
        while (!rsp_valid && guard < 60) begin
            @(negedge clk);
            guard++;
        end
        chk(rsp_valid == 1'b1, "R7", "response arrived", {31'd0, rsp_valid}, 32'd1);
        chk(seen_addr == ea, "R2", "entry address", seen_addr, ea);
        chk(seen_cnt == start_cnt + 1, "R7", "one read per walk", seen_cnt, start_cnt + 1);
        chk(rsp_vaddr == va, "R5", "reported vaddr", rsp_vaddr, va);
        if (pte[31]) begin
            chk(rsp_fault == 1'b0, "R4", "no fault", {31'd0, rsp_fault}, 32'd0);
            chk(rsp_paddr == {pte[17:0], va[11:0]}, "R4", "paddr",
                {2'b0, rsp_paddr}, {2'b0, pte[17:0], va[11:0]});
            chk(rsp_attr == pte[30:18], "R4", "attr", {19'd0, rsp_attr}, {19'd0, pte[30:18]});
        end else begin
            chk(rsp_fault == 1'b1, "R5", "fault flag", {31'd0, rsp_fault}, 32'd1);
            chk(rsp_paddr == '0 && rsp_attr == '0, "R5", "zero on fault",
                {2'b0, rsp_paddr}, 32'd0);
        end
        p0 = rsp_paddr;
        f0 = rsp_fault;
        for (int h = 0; h < hold; h++) begin
            @(negedge clk);
            chk(rsp_valid && rsp_paddr == p0 && rsp_fault == f0, "R8", "held result",
                {2'b0, rsp_paddr}, {2'b0, p0});
        end
        rsp_ready = 1'b1;
        @(negedge clk);
        rsp_ready = 1'b0;
        chk(!rsp_valid && req_ready, "R8", "idle after handshake",
            {30'd0, rsp_valid, req_ready}, 32'd1);
        if (ctxmid) cur_base = newbase;
    endtask

    initial begin
        #(8 * 150000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired act=%0d exp=%0d", 1, 0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [31:0] bases [3];
        bases[0] = 32'h0010_0000;
        bases[1] = 32'h8000_0004;
        bases[2] = 32'hFFE0_0000;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk(req_ready == 1'b1, "R1", "req_ready", {31'd0, req_ready}, 32'd1);
        chk(mem_req_valid == 1'b0, "R1", "mem_req_valid", {31'd0, mem_req_valid}, 32'd0);
        chk(rsp_valid == 1'b0, "R1", "rsp_valid", {31'd0, rsp_valid}, 32'd0);
        // R1: walk with the reset base of zero
        cur_base = 32'h0;
        walk(32'h0000_3ABC, 0, 1'b0, 1'b0, 32'h0);

        // R9: stray memory response while idle
        @(negedge clk);
        mem_rsp_valid = 1'b1;
        mem_rsp_data = 32'h8000_1234;
        @(negedge clk);
        mem_rsp_valid = 1'b0;
        mem_rsp_data = '0;
        @(negedge clk);
        chk(rsp_valid == 1'b0 && req_ready == 1'b1, "R9", "stray response ignored",
            {30'd0, rsp_valid, req_ready}, 32'd1);

        // R3: load in the same cycle as acceptance applies to the next walk
        @(negedge clk);
        req_valid = 1'b1;
        req_vaddr = 32'h0000_5000;
        ctx_load = 1'b1;
        ctx_base = 32'h4000_0000;
        @(negedge clk);
        req_valid = 1'b0;
        ctx_load = 1'b0;
        while (!rsp_valid) @(negedge clk);
        chk(seen_addr == 32'h0000_0014, "R3", "old base on same-cycle load",
            seen_addr, 32'h0000_0014);
        rsp_ready = 1'b1;
        @(negedge clk);
        rsp_ready = 1'b0;
        cur_base = 32'h4000_0000;
        walk(32'h0000_5000, 0, 1'b0, 1'b0, 32'h0);

        for (int b = 0; b < 3; b++) begin
            set_base(bases[b]);
            for (int k = 0; k < 40; k++) begin
                logic [19:0] vpn;
                logic [31:0] va;
                if (k < 8) vpn = 20'(k);
                else if (k < 16) vpn = 20'hFFFFF - 20'(k - 8);
                else vpn = 20'(k * 32'h1F3B7);
                va = {vpn, 12'(k * 12'h155)};
                mlat = k % 4;
                mstall = (k % 5 == 0);
                // R3: a switch in mid-walk on one walk per base
                walk(va, k % 3, (k % 7 == 3), (k == 20), bases[(b + 1) % 3]);
                if (k == 20) set_base(bases[b]);
            end
        end
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule